// File: doc/BRIEF.md
# Status Reporting Group with Edge-Qualified Event Latching

This block gathers fault flags from a three-phase power stage into one 16-bit status word. Each condition bit is the OR of the matching flag from all three phases and is registered once per clock. Two per-bit filter registers decide which changes of a condition bit count as an event. One filter admits rising changes and the other admits falling changes. Admitted changes latch into a sticky event register. A software read of that register returns its contents and empties it.

An enable mask selects which event bits feed a single summary output. A controller can poll that output instead of reading the full word.

A small register port gives write access to the two filters and the enable mask. It gives read access to all five registers.

Only eight bit positions carry a fault meaning:

| Bit | Fault |
|-----|-------|
| 0 | output over-voltage trip |
| 1 | output over-current trip |
| 3 | output not regulated |
| 4 | over-temperature |
| 9 | remote inhibit |
| 11 | input phase missing |
| 12 | rms current limiting |
| 13 | summary from a lower group |

Every other position is hardwired to zero.

Top module: `stat_group_top`

## Requirements
- R1: The condition register bit k equals the OR of `phase_flags[k]`, `phase_flags[16+k]` and `phase_flags[32+k]`, registered on the next clock edge.
- R2: When a bit is set in both filters, a rise or a fall of that condition bit sets the event bit. The event bit becomes visible one clock after the condition register changes.
- R3: When a bit is clear in both filters, no change of that condition bit sets the event bit.
- R4: When only the rising filter bit is set, only a 0-to-1 change of the condition bit sets the event bit. When only the falling filter bit is set, only a 1-to-0 change sets it.
- R5: Event bits stay set across later condition changes until the event register is read. That read returns the pre-clear value, and the register is zero afterwards.
- R6: After reset, both filters, the enable mask, the condition register, the event register and `summary` are all zero.
- R7: A write to a filter register sets event bits directly, using the condition register value at the moment of the write.
  - A bit newly set in the rising filter sets its event bit when its condition bit is 1.
  - A bit newly set in the falling filter sets its event bit when its condition bit is 0.
- R8: Only bits 0, 1, 3, 4, 9, 11, 12 and 13 (mask 0x3A1B) are implemented. Every other bit of the condition and event registers reads 0.
- R9: If an event bit is set in the same cycle as a clearing read of the event register, it is still set after that clear.
- R10: `summary` is 1 exactly when some bit is set in both the event register and the enable mask. It follows the registers in the same cycle.
- R11: Writes to unimplemented bits of the filter and enable registers are ignored, and those bits read back as 0.
- R12: Register addresses are as follows:
  - 0: condition
  - 1: event (clears on read)
  - 2: rising filter
  - 3: falling filter
  - 4: enable mask

  Other addresses read 0. `rd_data` is loaded on the clock edge where `rd_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_flags | input | 48 | Per-phase fault flags, phase p at bits [16p+15:16p] |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |
| summary | output | 1 | OR of enabled event bits |

## Verification
Some internal faults show up at the ports quickly:
- A wrong previous-condition register produces a spurious or missing event bit, seen on the next event read, two clocks after the flag changes.
- A broken clear shows as a second read that returns a nonzero value.
- A lost collision event shows as a zero on the read that follows the collision.

Summary faults appear on `summary` in the same cycle the mask or event register changes.

The bench sweeps every implemented bit through all four filter combinations, in both directions. It drives each bit through a different phase.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned STAT_W = 16;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_COND  = 3'd0,
    RA_EVENT = 3'd1,
    RA_RISE  = 3'd2,
    RA_FALL  = 3'd3,
    RA_ENA   = 3'd4
  } reg_addr_e;

  // Changes of cond admitted by the two filters.
  function automatic logic [STAT_W-1:0] edge_hits(
    input logic [STAT_W-1:0] cur,
    input logic [STAT_W-1:0] prev,
    input logic [STAT_W-1:0] rise_f,
    input logic [STAT_W-1:0] fall_f
  );
    return (cur & ~prev & rise_f) | (~cur & prev & fall_f);
  endfunction

  // Events caused by arming a filter bit: level must already match.
  function automatic logic [STAT_W-1:0] arm_hits(
    input logic [STAT_W-1:0] cur,
    input logic [STAT_W-1:0] old_f,
    input logic [STAT_W-1:0] new_f,
    input logic              rising
  );
    logic [STAT_W-1:0] fresh;
    fresh = new_f & ~old_f;
    return rising ? (fresh & cur) : (fresh & ~cur);
  endfunction
endpackage

// File: rtl/stat_cond_capture.sv
module stat_cond_capture
  import stat_pkg::*;
#(
  parameter int unsigned PHASES = 3,
  parameter logic [STAT_W-1:0] USED = 16'h3A1B
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PHASES*STAT_W-1:0] phase_flags,
  output logic [STAT_W-1:0]        cond_q,
  output logic [STAT_W-1:0]        cond_prev
);
  logic [STAT_W-1:0] merged [PHASES+1];

  assign merged[0] = '0;

  generate
    for (genvar p = 0; p < PHASES; p++) begin : g_phase
      assign merged[p+1] = merged[p] | phase_flags[p*STAT_W +: STAT_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q    <= '0;
      cond_prev <= '0;
    end else begin
      cond_q    <= merged[PHASES] & USED;
      cond_prev <= cond_q;
    end
  end
endmodule

// File: rtl/stat_edge_filter.sv
module stat_edge_filter
  import stat_pkg::*;
#(
  parameter logic [STAT_W-1:0] USED = 16'h3A1B
) (
  input  logic [STAT_W-1:0] cond_q,
  input  logic [STAT_W-1:0] cond_prev,
  input  logic [STAT_W-1:0] rise_q,
  input  logic [STAT_W-1:0] fall_q,
  input  logic              rise_wr,
  input  logic              fall_wr,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] edge_bits,
  output logic [STAT_W-1:0] arm_bits,
  output logic [STAT_W-1:0] set_bits
);
  logic [STAT_W-1:0] new_f;
  logic [STAT_W-1:0] arm_r;
  logic [STAT_W-1:0] arm_f;

  always_comb begin
    new_f     = wr_data & USED;
    edge_bits = edge_hits(cond_q, cond_prev, rise_q, fall_q);
    arm_r     = rise_wr ? arm_hits(cond_q, rise_q, new_f, 1'b1) : '0;
    arm_f     = fall_wr ? arm_hits(cond_q, fall_q, new_f, 1'b0) : '0;
    arm_bits  = arm_r | arm_f;
    set_bits  = (edge_bits | arm_bits) & USED;
  end
endmodule

// File: rtl/stat_event_reg.sv
module stat_event_reg
  import stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_bits,
  input  logic              clr,
  output logic [STAT_W-1:0] ev_q
);
  logic [STAT_W-1:0] kept;

  // A new set wins over a same-cycle clear.
  always_comb kept = clr ? '0 : ev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= kept | set_bits;
  end
endmodule

// File: rtl/stat_regbank.sv
module stat_regbank
  import stat_pkg::*;
#(
  parameter logic [STAT_W-1:0] USED = 16'h3A1B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [STAT_W-1:0] cond_q,
  input  logic [STAT_W-1:0] ev_q,
  output logic [STAT_W-1:0] rise_q,
  output logic [STAT_W-1:0] fall_q,
  output logic [STAT_W-1:0] ena_q,
  output logic              rise_wr,
  output logic              fall_wr,
  output logic              ev_clr,
  output logic [STAT_W-1:0] rd_data
);
  logic              ena_wr;
  logic [STAT_W-1:0] rd_mux;

  always_comb begin
    rise_wr = wr_en && (reg_addr_e'(wr_addr) == RA_RISE);
    fall_wr = wr_en && (reg_addr_e'(wr_addr) == RA_FALL);
    ena_wr  = wr_en && (reg_addr_e'(wr_addr) == RA_ENA);
    ev_clr  = rd_en && (reg_addr_e'(rd_addr) == RA_EVENT);
  end

  always_comb begin
    case (reg_addr_e'(rd_addr))
      RA_COND:  rd_mux = cond_q;
      RA_EVENT: rd_mux = ev_q;
      RA_RISE:  rd_mux = rise_q;
      RA_FALL:  rd_mux = fall_q;
      RA_ENA:   rd_mux = ena_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_q  <= '0;
      fall_q  <= '0;
      ena_q   <= '0;
      rd_data <= '0;
    end else begin
      if (rise_wr) rise_q <= wr_data & USED;
      if (fall_wr) fall_q <= wr_data & USED;
      if (ena_wr)  ena_q  <= wr_data & USED;
      if (rd_en)   rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/stat_group_top.sv
module stat_group_top
  import stat_pkg::*;
#(
  parameter int unsigned PHASES = 3,
  parameter logic [STAT_W-1:0] USED_MASK = 16'h3A1B
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PHASES*STAT_W-1:0] phase_flags,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [STAT_W-1:0]        wr_data,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [STAT_W-1:0]        rd_data,
  output logic                     summary
);
  logic [STAT_W-1:0] cond_q, cond_prev;
  logic [STAT_W-1:0] rise_q, fall_q, ena_q, ev_q;
  logic [STAT_W-1:0] edge_bits, arm_bits, set_bits;
  logic              rise_wr, fall_wr, ev_clr;

  stat_cond_capture #(.PHASES(PHASES), .USED(USED_MASK)) u_cond (
    .clk(clk), .rst_n(rst_n), .phase_flags(phase_flags),
    .cond_q(cond_q), .cond_prev(cond_prev)
  );

  stat_edge_filter #(.USED(USED_MASK)) u_filt (
    .cond_q(cond_q), .cond_prev(cond_prev), .rise_q(rise_q), .fall_q(fall_q),
    .rise_wr(rise_wr), .fall_wr(fall_wr), .wr_data(wr_data),
    .edge_bits(edge_bits), .arm_bits(arm_bits), .set_bits(set_bits)
  );

  stat_event_reg u_evt (
    .clk(clk), .rst_n(rst_n), .set_bits(set_bits), .clr(ev_clr), .ev_q(ev_q)
  );

  stat_regbank #(.USED(USED_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .cond_q(cond_q),
    .ev_q(ev_q), .rise_q(rise_q), .fall_q(fall_q), .ena_q(ena_q),
    .rise_wr(rise_wr), .fall_wr(fall_wr), .ev_clr(ev_clr), .rd_data(rd_data)
  );

  assign summary = |(ev_q & ena_q);
endmodule

// File: rtl/stat_group_chk.sv
module stat_group_chk
  import stat_pkg::*;
#(
  parameter int unsigned PHASES = 3,
  parameter logic [STAT_W-1:0] USED = 16'h3A1B
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [PHASES*STAT_W-1:0] phase_flags,
  input logic [STAT_W-1:0]        cond_q,
  input logic [STAT_W-1:0]        rise_q,
  input logic [STAT_W-1:0]        fall_q,
  input logic [STAT_W-1:0]        ena_q,
  input logic [STAT_W-1:0]        ev_q,
  input logic [STAT_W-1:0]        set_bits,
  input logic                     rise_wr,
  input logic                     fall_wr,
  input logic                     ev_clr,
  input logic                     summary
);
  logic [STAT_W-1:0] any_phase;

  always_comb begin
    any_phase = '0;
    for (int p = 0; p < PHASES; p++) any_phase |= phase_flags[p*STAT_W +: STAT_W];
  end

  AST_COND_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cond_q == ($past(any_phase) & USED))); // R1

  AST_NO_FILTER_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_wr && !fall_wr) |=> ((ev_q & ~$past(ev_q) & ~$past(rise_q | fall_q)) == '0)); // R3

  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_clr |=> ((ev_q & $past(ev_q)) == $past(ev_q))); // R5

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clr && set_bits == '0) |=> (ev_q == '0)); // R5

  AST_CLASH_KEEPS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr |=> ((ev_q & $past(set_bits)) == $past(set_bits))); // R9

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_q | rise_q | fall_q | ena_q | cond_q) & ~USED) == '0); // R11

  AST_SUMMARY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0) |-> !summary); // R10
endmodule

bind stat_group_top stat_group_chk #(.PHASES(PHASES), .USED(USED_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_flags(phase_flags), .cond_q(cond_q),
  .rise_q(rise_q), .fall_q(fall_q), .ena_q(ena_q), .ev_q(ev_q),
  .set_bits(set_bits), .rise_wr(rise_wr), .fall_wr(fall_wr),
  .ev_clr(ev_clr), .summary(summary)
);

// File: tb/stat_group_top_test.sv
module stat_group_top_test;
  localparam logic [15:0] USED = 16'h3A1B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] phase_flags = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        summary;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stat_group_top uut (
    .clk(clk), .rst_n(rst_n), .phase_flags(phase_flags), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .summary(summary)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  initial begin
    logic [15:0] v;
    logic [15:0] bit_m;
    @(negedge clk);
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R6: everything is zero after reset
    for (int a = 0; a < 5; a++) begin
      bus_read(3'(a), v);
      check($sformatf("R6 reset addr %0d", a), v, 16'h0);
    end
    check("R6 summary after reset", {15'h0, summary}, 16'h0);
    bus_read(3'd6, v);
    check("R12 unmapped address", v, 16'h0);

    // Sweep every implemented bit through all filter combinations.
    for (int b = 0; b < 16; b++) begin
      if (USED[b]) begin
        bit_m = 16'h1 << b;
        for (int c = 0; c < 4; c++) begin
          string tag;
          tag = (c == 3) ? "R2" : (c == 0) ? "R3" : "R4";
          bus_write(3'd2, c[0] ? bit_m : 16'h0);
          bus_write(3'd3, c[1] ? bit_m : 16'h0);
          // Arming the falling filter while the condition is 0 sets an event.
          bus_read(3'd1, v);
          check($sformatf("R7 arm fall bit %0d combo %0d", b, c), v, c[1] ? bit_m : 16'h0);
          phase_flags[(b % 3) * 16 + b] = 1'b1;
          tick(3);
          bus_read(3'd0, v);
          check($sformatf("R1 cond bit %0d phase %0d", b, b % 3), v, bit_m);
          bus_read(3'd1, v);
          check($sformatf("%s rise bit %0d combo %0d", tag, b, c), v, c[0] ? bit_m : 16'h0);
          phase_flags[(b % 3) * 16 + b] = 1'b0;
          tick(3);
          bus_read(3'd1, v);
          check($sformatf("%s fall bit %0d combo %0d", tag, b, c), v, c[1] ? bit_m : 16'h0);
          bus_write(3'd2, 16'h0);
          bus_write(3'd3, 16'h0);
        end
      end
    end

    // R5: sticky across later changes, read clears
    bus_write(3'd2, 16'h0010);
    phase_flags[16+4] = 1'b1;
    tick(3);
    phase_flags[16+4] = 1'b0;
    tick(3);
    bus_read(3'd1, v);
    check("R5 sticky after condition returned", v, 16'h0010);
    bus_read(3'd1, v);
    check("R5 second read empty", v, 16'h0);
    bus_write(3'd2, 16'h0);

    // R9 + R7: arm the rising filter in the same cycle as a clearing read
    phase_flags[0] = 1'b1;
    tick(3);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'h0001;
    rd_en = 1'b1; rd_addr = 3'd1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R9 clash read returns old value", rd_data, 16'h0);
    bus_read(3'd1, v);
    check("R9 R7 event survives clash", v, 16'h0001);

    // R10: summary gated by enable mask
    bus_write(3'd2, 16'h0);
    bus_write(3'd2, 16'h0001);
    check("R10 summary with mask 0", {15'h0, summary}, 16'h0);
    bus_write(3'd4, 16'h0002);
    check("R10 summary other bit enabled", {15'h0, summary}, 16'h0);
    bus_write(3'd4, 16'h0001);
    check("R10 summary enabled bit", {15'h0, summary}, 16'h1);
    bus_read(3'd1, v);
    check("R10 summary drops after clear", {15'h0, summary}, 16'h0);
    bus_write(3'd2, 16'h0);
    phase_flags[0] = 1'b0;
    tick(3);

    // R11: unimplemented bits ignored
    bus_write(3'd2, 16'hFFFF);
    bus_read(3'd2, v);
    check("R11 rising filter readback", v, USED);
    bus_write(3'd3, 16'hFFFF);
    bus_read(3'd3, v);
    check("R11 falling filter readback", v, USED);
    bus_write(3'd4, 16'hFFFF);
    bus_read(3'd4, v);
    check("R11 enable readback", v, USED);

    // R8: all flags high only shows implemented bits
    phase_flags = '1;
    tick(3);
    bus_read(3'd0, v);
    check("R8 condition map", v, USED);
    bus_read(3'd1, v);
    check("R8 event map", v, USED);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule